// File: doc/BRIEF.md
# Interrupt Redirection Table

This block sits between a set of interrupt input lines and the fabric that routes interrupt messages to processors. Each of its 24 input lines owns a 64-bit routing entry. The entry gives the vector, the delivery mode, the destination and its addressing mode, the polarity, the trigger style and a mask. Software never addresses an entry directly. It first writes an index into a select register, then reads or writes 32 bits at a time through a data window. Each entry is split into an even-indexed low word and an odd-indexed high word.

The block samples the input lines every cycle. A line in edge mode latches a pending flag on a rising input. A line in level mode counts as pending for as long as it is high. Among the unmasked pending lines, the lowest-numbered one wins. Its routing fields are captured into a delivery request that is offered on a valid/ready handshake. Accepting an edge-mode request consumes its pending flag. A level-mode line keeps requesting while its input stays high.

Top module: `irq_route_table`

## Requirements
- R1: After reset no request is offered, the identifier reads 0, and every entry reads 0x0001_0000 in its low word and 0 in its high word, so only the mask bit (bit 16) is set.
- R2: The select register is written and read back at acc_addr 0x00, and the data window is at acc_addr 0x10.
- R3: Window index 0 holds an 8-bit identifier in bits 31:24; the other bits read 0.
- R4: Window index 1 reads 0x0017_0011: version 0x11 in bits 7:0 and the highest entry number, 23, in bits 23:16. Writes to it are ignored.
- R5: Entry n is reached at index 0x10+2n for its low word and at 0x11+2n for its high word. Writing one word leaves the other word unchanged.
- R6: Window indices 0x02 to 0x0F and from 0x40 upward read 0, and writes to them change nothing.
- R7: A request carries the fields of the chosen entry: vector from bits 7:0, delivery mode from bits 10:8, destination mode from bit 11, polarity from bit 13, trigger from bit 15 (1 = level), and destination from bits 63:56. It also carries the pin number.
- R8: A line whose entry has bit 16 set is never offered. An edge that arrives while the line is masked stays pending and is offered once the mask is cleared.
- R9: An edge-mode line becomes pending on a rising input and is offered once per rising edge. The accepted request clears the pending flag.
- R10: A level-mode line is offered in every cycle that its input is high, also directly after it has been accepted, and is not offered when its input is low.
- R11: When several lines are pending, the lowest-numbered line is offered first.
- R12: While dlv_valid is high and dlv_ready is low, the request and all its fields hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | 0x00 = select register, 0x10 = data window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr (combinational) |
| irq_in | input | 24 | Interrupt input lines |
| dlv_valid | output | 1 | Delivery request offered |
| dlv_ready | input | 1 | Delivery request accepted |
| dlv_pin | output | 5 | Number of the line being delivered |
| dlv_dest | output | 8 | Destination |
| dlv_dest_mode | output | 1 | Destination addressing mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Vector |
| dlv_polarity | output | 1 | Input polarity bit |
| dlv_trigger | output | 1 | 1 = level, 0 = edge |

## Verification
The assertions assume that irq_in and dlv_ready are synchronous to clk and free of glitches. They also assume that an acceptance cycle is marked only by dlv_ready being high while dlv_valid is high. The level-source check relies on the input value seen at the clock edge where the request appeared. The bench changes every input at the falling edge. It holds dlv_ready low across several cycles to exercise the hold rule. It lowers each line for at least one clock before raising it again, so that every rising edge is a real one.

// File: rtl/irq_route_table.sv
module irq_route_table #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W = 8,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_wr,
  input  logic [4:0]          acc_addr,
  input  logic [31:0]         acc_wdata,
  output logic [31:0]         acc_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                dlv_valid,
  input  logic                dlv_ready,
  output logic [PIN_W-1:0]    dlv_pin,
  output logic [7:0]          dlv_dest,
  output logic                dlv_dest_mode,
  output logic [2:0]          dlv_mode,
  output logic [7:0]          dlv_vector,
  output logic                dlv_polarity,
  output logic                dlv_trigger
);
  localparam logic [IDX_W-1:0] ENT_LO  = IDX_W'(16);
  localparam logic [IDX_W-1:0] ENT_END = IDX_W'(16 + 2 * NUM_PINS);

  logic [IDX_W-1:0]    sel_q;
  logic [7:0]          id_q;
  logic [63:0]         ent_q [NUM_PINS];
  logic [NUM_PINS-1:0] irq_d, edge_pend, lvl_v, req, take, req_eff;
  logic [PIN_W-1:0]    pick;
  logic                any;

  wire             wr_sel  = acc_en & acc_wr & (acc_addr == 5'h00);
  wire             wr_win  = acc_en & acc_wr & (acc_addr == 5'h10);
  wire             in_tab  = (sel_q >= ENT_LO) && (sel_q < ENT_END);
  wire [IDX_W-1:0] ent_off = sel_q - ENT_LO;
  wire [PIN_W-1:0] sel_pin = PIN_W'(ent_off >> 1);
  wire             hs      = dlv_valid & dlv_ready;

  always_comb begin
    acc_rdata = '0;
    if (acc_addr == 5'h00)
      acc_rdata = 32'(sel_q);
    else if (acc_addr == 5'h10) begin
      if (sel_q == '0)
        acc_rdata = {id_q, 24'h0};
      else if (sel_q == IDX_W'(1))
        acc_rdata = {8'h0, 8'(NUM_PINS - 1), 8'h0, VERSION};
      else if (in_tab)
        acc_rdata = sel_q[0] ? ent_q[sel_pin][63:32] : ent_q[sel_pin][31:0];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign lvl_v[p]   = ent_q[p][15];
    assign req[p]     = !ent_q[p][16] && (lvl_v[p] ? irq_in[p] : edge_pend[p]);
    assign take[p]    = hs && !dlv_trigger && (dlv_pin == PIN_W'(p));
    assign req_eff[p] = req[p] && !take[p];
  end

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int p = NUM_PINS - 1; p >= 0; p--)
      if (req_eff[p]) begin
        pick = PIN_W'(p);
        any  = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      id_q      <= '0;
      irq_d     <= '0;
      edge_pend <= '0;
      for (int p = 0; p < NUM_PINS; p++) ent_q[p] <= 64'h0000_0000_0001_0000;
    end else begin
      irq_d <= irq_in;
      if (wr_sel) sel_q <= acc_wdata[IDX_W-1:0];
      if (wr_win && sel_q == '0) id_q <= acc_wdata[31:24];
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_win && in_tab && sel_pin == PIN_W'(p)) begin
          if (sel_q[0]) ent_q[p][63:32] <= acc_wdata;
          else          ent_q[p][31:0]  <= acc_wdata;
        end
        if (irq_in[p] && !irq_d[p] && !lvl_v[p]) edge_pend[p] <= 1'b1;
        else if (take[p] || lvl_v[p])             edge_pend[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_valid     <= 1'b0;
      dlv_pin       <= '0;
      dlv_dest      <= '0;
      dlv_dest_mode <= 1'b0;
      dlv_mode      <= '0;
      dlv_vector    <= '0;
      dlv_polarity  <= 1'b0;
      dlv_trigger   <= 1'b0;
    end else if (!dlv_valid || dlv_ready) begin
      dlv_valid     <= any;
      dlv_pin       <= pick;
      dlv_dest      <= ent_q[pick][63:56];
      dlv_dest_mode <= ent_q[pick][11];
      dlv_mode      <= ent_q[pick][10:8];
      dlv_vector    <= ent_q[pick][7:0];
      dlv_polarity  <= ent_q[pick][13];
      dlv_trigger   <= ent_q[pick][15];
    end
  end
endmodule

// File: rtl/irq_route_table_chk.sv
module irq_route_table_chk #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] irq_in,
  input logic                dlv_valid,
  input logic                dlv_ready,
  input logic [PIN_W-1:0]    dlv_pin,
  input logic [7:0]          dlv_dest,
  input logic                dlv_dest_mode,
  input logic [2:0]          dlv_mode,
  input logic [7:0]          dlv_vector,
  input logic                dlv_polarity,
  input logic                dlv_trigger
);
  logic [NUM_PINS-1:0] irq_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_in;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !dlv_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin) && $stable(dlv_dest)
      && $stable(dlv_dest_mode) && $stable(dlv_mode) && $stable(dlv_vector)
      && $stable(dlv_polarity) && $stable(dlv_trigger));

  a_r9_edge_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_ready && !dlv_trigger |=> !(dlv_valid && dlv_pin == $past(dlv_pin)));

  a_r10_level_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) && dlv_trigger |-> irq_q[dlv_pin]);
endmodule

bind irq_route_table irq_route_table_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/irq_route_table_tb.sv
`timescale 1ns/1ps
module irq_route_table_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [4:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [23:0] irq_in = '0;
  logic        dlv_valid, dlv_ready = 1'b0;
  logic [4:0]  dlv_pin;
  logic [7:0]  dlv_dest, dlv_vector;
  logic        dlv_dest_mode, dlv_polarity, dlv_trigger;
  logic [2:0]  dlv_mode;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_route_table u_dut (.*);

  // {write, window, requirement, data}; a read compares the window/select against data
  localparam int NV = 26;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd2, 32'h0000_0014},
    {1'b0, 1'b1, 4'd1, 32'h0001_0000},  // R1 low word after reset
    {1'b0, 1'b0, 4'd2, 32'h0000_0014},  // R2 select readback
    {1'b1, 1'b0, 4'd2, 32'h0000_0015},
    {1'b0, 1'b1, 4'd1, 32'h0000_0000},  // R1 high word after reset
    {1'b1, 1'b1, 4'd5, 32'hAB00_0000},
    {1'b1, 1'b0, 4'd5, 32'h0000_0014},
    {1'b0, 1'b1, 4'd5, 32'h0001_0000},  // R5 low kept
    {1'b1, 1'b1, 4'd5, 32'h0000_2BC5},
    {1'b0, 1'b1, 4'd5, 32'h0000_2BC5},  // R5
    {1'b1, 1'b0, 4'd5, 32'h0000_0015},
    {1'b0, 1'b1, 4'd5, 32'hAB00_0000},  // R5 high kept
    {1'b1, 1'b0, 4'd3, 32'h0000_0000},
    {1'b1, 1'b1, 4'd3, 32'hFFFF_FFFF},
    {1'b0, 1'b1, 4'd3, 32'hFF00_0000},  // R3
    {1'b1, 1'b0, 4'd4, 32'h0000_0001},
    {1'b0, 1'b1, 4'd4, 32'h0017_0011},  // R4
    {1'b1, 1'b1, 4'd4, 32'h0000_0000},
    {1'b0, 1'b1, 4'd4, 32'h0017_0011},  // R4 write ignored
    {1'b1, 1'b0, 4'd6, 32'h0000_0005},
    {1'b1, 1'b1, 4'd6, 32'h0000_1234},
    {1'b0, 1'b1, 4'd6, 32'h0000_0000},  // R6 hole
    {1'b1, 1'b0, 4'd6, 32'h0000_0040},
    {1'b1, 1'b1, 4'd6, 32'h0000_FFFF},
    {1'b0, 1'b1, 4'd6, 32'h0000_0000},  // R6 beyond table
    {1'b1, 1'b0, 4'd1, 32'h0000_003F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic acc_write(input logic win, input logic [31:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = win ? 5'h10 : 5'h00; acc_wdata = d;
    cyc(1);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic acc_read(input logic win, output logic [31:0] d);
    acc_addr = win ? 5'h10 : 5'h00;
    #1 d = acc_rdata;
  endtask

  task automatic entry(input logic [7:0] idx, input logic [31:0] d);
    acc_write(1'b0, 32'(idx));
    acc_write(1'b1, d);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    check("R1 idle", 32'(dlv_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) acc_write(VEC[i][36], VEC[i][31:0]);
      else begin
        acc_read(VEC[i][36], rd);
        check($sformatf("R%0d vec%0d", VEC[i][35:32], i), rd, VEC[i][31:0]);
      end
    end
    acc_read(1'b1, rd);
    check("R1 entry23 high", rd, 32'h0);

    // R9 / R7 / R12: pin 2 edge entry, ready held low
    irq_in[2] = 1'b1;
    cyc(2);
    check("R9 offered", 32'(dlv_valid), 32'd1);
    check("R7 pin", 32'(dlv_pin), 32'd2);
    check("R7 vector", 32'(dlv_vector), 32'hC5);
    check("R7 mode", 32'(dlv_mode), 32'd3);
    check("R7 dest mode", 32'(dlv_dest_mode), 32'd1);
    check("R7 polarity", 32'(dlv_polarity), 32'd1);
    check("R7 trigger", 32'(dlv_trigger), 32'd0);
    check("R7 dest", 32'(dlv_dest), 32'hAB);
    cyc(3);
    check("R12 hold valid", 32'(dlv_valid), 32'd1);
    check("R12 hold vector", 32'(dlv_vector), 32'hC5);
    dlv_ready = 1'b1;
    cyc(1);
    dlv_ready = 1'b0;
    check("R9 consumed", 32'(dlv_valid), 32'd0);
    cyc(3);
    check("R9 once per edge", 32'(dlv_valid), 32'd0);
    irq_in[2] = 1'b0;

    // R10: pin 5 level, dest 0x11, vector 0x40
    entry(8'h1B, 32'h1100_0000);
    entry(8'h1A, 32'h0000_8040);
    dlv_ready = 1'b1;
    irq_in[5] = 1'b1;
    cyc(1);
    check("R10 offered", 32'(dlv_valid), 32'd1);
    check("R10 pin", 32'(dlv_pin), 32'd5);
    check("R10 trigger", 32'(dlv_trigger), 32'd1);
    check("R10 dest", 32'(dlv_dest), 32'h11);
    cyc(2);
    check("R10 repeats", 32'(dlv_valid), 32'd1);
    irq_in[5] = 1'b0;
    cyc(1);
    check("R10 low idle", 32'(dlv_valid), 32'd0);
    dlv_ready = 1'b0;

    // R11: pins 2 and 7 together
    entry(8'h1E, 32'h0000_0077);
    irq_in[2] = 1'b1; irq_in[7] = 1'b1;
    cyc(2);
    check("R11 first", 32'(dlv_pin), 32'd2);
    dlv_ready = 1'b1;
    cyc(1);
    check("R11 second valid", 32'(dlv_valid), 32'd1);
    check("R11 second", 32'(dlv_pin), 32'd7);
    check("R11 vector", 32'(dlv_vector), 32'h77);
    cyc(1);
    dlv_ready = 1'b0;
    check("R11 drained", 32'(dlv_valid), 32'd0);
    irq_in[2] = 1'b0; irq_in[7] = 1'b0;

    // R8: masked edge kept until unmasked
    entry(8'h1E, 32'h0001_0077);
    irq_in[7] = 1'b1;
    cyc(4);
    check("R8 masked", 32'(dlv_valid), 32'd0);
    entry(8'h1E, 32'h0000_0077);
    cyc(1);
    check("R8 unmask offers", 32'(dlv_valid), 32'd1);
    check("R8 pin", 32'(dlv_pin), 32'd7);
    dlv_ready = 1'b1;
    cyc(1);
    dlv_ready = 1'b0;
    check("R8 consumed", 32'(dlv_valid), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule